// File: doc/BRIEF.md
# Mode-Selectable Event Flip-Flop Stage

This stage sits after two combined event signals, X0 and X1, and turns them into a primary output and a second output. A three-bit mode field selects the behaviour. In the pass-through mode, nothing is stored and each input reaches its own output. The other modes share one storage bit and make it act as a set/reset trigger, a toggle flip-flop, a D flip-flop, a JK flip-flop or a level latch. In the storing modes, the second output is the inverse of the stored bit.

X1 acts as the event clock. Its rising edges are found inside the system clock domain by comparing it with its value one cycle earlier, so every state change happens on a system clock edge. JK behaviour uses the D path. The logic upstream forms J&~Q | ~K&Q from the fed-back primary output and presents it on X0.

A force-initial control loads the stored bit with a chosen level. Two force-bypass bits, one for each path, send the raw input to its output in any mode.

Top module: `evff_stage`

## Requirements
- R1: After reset the stored bit is 0 and the remembered X1 sample is 0. X1 high in the first cycle after reset is therefore a rising edge.
- R2: Mode codes 0, 6 and 7 pass data straight through in the same cycle: qOut equals x0In and qnOut equals x1In.
- R3: In mode 1 (set/reset), x0In high clears the stored bit at the next clock edge and overrides x1In. x1In high alone sets it. Both inputs low hold it.
- R4: In mode 2 (toggle), the stored bit inverts on a system clock edge where x1In is rising and x0In is high. Otherwise it holds.
- R5: In mode 3 (D flip-flop), the stored bit takes x0In on a clock edge where x1In is rising and holds on every other edge.
- R6: Mode 4 (JK) captures like mode 3. With x0In driven as J&~Q | ~K&Q from qOut, J=K=1 toggles, J=1 K=0 sets, J=0 K=1 clears, and J=K=0 holds.
- R7: In mode 5 (latch), the stored bit takes x0In on every clock edge where x1In is high and holds while x1In is low.
- R8: In modes 1 to 5, with no force-bypass, qOut shows the stored bit and qnOut shows its inverse.
- R9: forceInit high at a clock edge loads initVal into the stored bit, taking priority over every mode action.
- R10: forceBypass[0] makes qOut equal x0In, and forceBypass[1] makes qnOut equal x1In, in any mode and in the same cycle.
- R11: A rising edge means x1In is high in this cycle and was low in the previous one. Holding x1In high for several cycles gives only one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Behaviour select (0 pass, 1 set/reset, 2 toggle, 3 D, 4 JK, 5 latch) |
| x0In | input | 1 | First combined event input (reset, toggle enable or data) |
| x1In | input | 1 | Second combined event input (set, event clock or enable) |
| forceInit | input | 1 | Load initVal into the stored bit at the next edge |
| initVal | input | 1 | Level loaded by forceInit |
| forceBypass | input | 2 | Per-path raw pass: bit 0 primary, bit 1 second output |
| qOut | output | 1 | Primary output |
| qnOut | output | 1 | Second output |

## Verification
The bench builds the stage with its default reset level of 0. This default is what makes the reset-state and first-edge-after-reset checks line up with R1. A seeded random phase changes the mode every few dozen cycles and covers all eight codes, including the two unused ones. It mixes rare force pulses and bypass bits with free-running X1 activity, so edges, held-high X1 and mode switches with a stored bit already set all occur. Directed sequences close the loop on JK feedback through qOut, set and reset asserted together, a force that collides with an active reset, and a long high level on X1.

// File: rtl/evff_pkg.sv
package evff_pkg;

  // Width of the behaviour select field
  localparam int MODE_W = 3;

  // Number of output paths (primary and second)
  localparam int NUM_PATHS = 2;

  // Behaviour codes; any code not listed behaves as pass-through
  typedef enum logic [MODE_W-1:0] {
    MODE_PASS = 3'd0,
    MODE_SR   = 3'd1,
    MODE_TOG  = 3'd2,
    MODE_DFF  = 3'd3,
    MODE_JK   = 3'd4,
    MODE_LAT  = 3'd5
  } evffMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic storing;  // outputs come from the stored bit
    logic load;     // write loadVal into the stored bit
    logic loadVal;  // value written on load
    logic toggle;   // invert the stored bit
  } evffStrobe_t;

endpackage

// File: rtl/evff_ctrl.sv
module evff_ctrl
  import evff_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              x0In,
  input  logic              x1In,
  input  logic              forceInit,
  input  logic              initVal,
  output evffStrobe_t       strb
);

  logic x1Prev;
  logic riseX1;

  // Remember X1 from the previous system cycle for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) x1Prev <= 1'b0;
    else       x1Prev <= x1In;
  end

  assign riseX1 = x1In & ~x1Prev;

  // Translate the mode and inputs into datapath strobes
  always_comb begin
    strb = '0;
    case (modeSel)
      MODE_SR: begin
        strb.storing = 1'b1;
        if (x0In) begin
          strb.load    = 1'b1;
          strb.loadVal = 1'b0;
        end else if (x1In) begin
          strb.load    = 1'b1;
          strb.loadVal = 1'b1;
        end
      end
      MODE_TOG: begin
        strb.storing = 1'b1;
        strb.toggle  = riseX1 & x0In;
      end
      MODE_DFF, MODE_JK: begin
        strb.storing = 1'b1;
        strb.load    = riseX1;
        strb.loadVal = x0In;
      end
      MODE_LAT: begin
        strb.storing = 1'b1;
        strb.load    = x1In;
        strb.loadVal = x0In;
      end
      default: begin
        strb.storing = 1'b0;
      end
    endcase
    // Forced initial value wins over every mode action
    if (forceInit) begin
      strb.load    = 1'b1;
      strb.loadVal = initVal;
      strb.toggle  = 1'b0;
    end
  end

  // Two rising edges can never occur in consecutive cycles
  assert_edge_single_R11 : assert property (
    @(posedge clk) disable iff (!rstN) riseX1 |=> !riseX1
  );

  // Load and toggle are never requested together
  assert_strobe_excl_R9 : assert property (
    @(posedge clk) disable iff (!rstN) !(strb.load && strb.toggle)
  );

endmodule

// File: rtl/evff_datapath.sv
module evff_datapath
  import evff_pkg::*;
#(
  parameter logic RESET_Q = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  evffStrobe_t          strb,
  input  logic                 x0In,
  input  logic                 x1In,
  input  logic [NUM_PATHS-1:0] forceBypass,
  output logic                 qOut,
  output logic                 qnOut
);

  logic                 qReg;
  logic [NUM_PATHS-1:0] srcVal;
  logic [NUM_PATHS-1:0] storedVal;
  logic [NUM_PATHS-1:0] pathOut;

  // The single storage bit shared by all storing modes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            qReg <= RESET_Q;
    else if (strb.load)   qReg <= strb.loadVal;
    else if (strb.toggle) qReg <= ~qReg;
  end

  assign srcVal    = {x1In, x0In};
  assign storedVal = {~qReg, qReg};

  // Each path picks its raw input or the stored view
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    assign pathOut[p] = (forceBypass[p] || !strb.storing) ? srcVal[p] : storedVal[p];
  end

  assign qOut  = pathOut[0];
  assign qnOut = pathOut[1];

  // Without load or toggle the stored bit holds
  assert_hold_R4 : assert property (
    @(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.toggle) |=> $stable(qReg)
  );

  // A toggle request always changes the stored bit
  assert_toggle_flip_R4 : assert property (
    @(posedge clk) disable iff (!rstN)
    strb.toggle |=> (qReg != $past(qReg))
  );

  // Storing modes without bypass give complementary outputs
  assert_compl_R8 : assert property (
    @(posedge clk) disable iff (!rstN)
    (strb.storing && forceBypass == '0) |-> (qnOut == ~qOut)
  );

endmodule

// File: rtl/evff_stage.sv
module evff_stage
  import evff_pkg::*;
#(
  parameter logic RESET_Q = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_W-1:0]    modeSel,
  input  logic                 x0In,
  input  logic                 x1In,
  input  logic                 forceInit,
  input  logic                 initVal,
  input  logic [NUM_PATHS-1:0] forceBypass,
  output logic                 qOut,
  output logic                 qnOut
);

  evffStrobe_t strb;

  evff_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .x0In      (x0In),
    .x1In      (x1In),
    .forceInit (forceInit),
    .initVal   (initVal),
    .strb      (strb)
  );

  evff_datapath #(
    .RESET_Q (RESET_Q)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .x0In        (x0In),
    .x1In        (x1In),
    .forceBypass (forceBypass),
    .qOut        (qOut),
    .qnOut       (qnOut)
  );

  logic storeCode;
  assign storeCode = (modeSel >= 3'd1) && (modeSel <= 3'd5);

  // Pass-through codes route both inputs unchanged
  assert_pass_R2 : assert property (
    @(posedge clk) disable iff (!rstN)
    (!storeCode && forceBypass == '0) |-> (qOut == x0In && qnOut == x1In)
  );

  // Primary bypass bit routes x0In in any mode
  assert_fbyp_R10 : assert property (
    @(posedge clk) disable iff (!rstN)
    forceBypass[0] |-> (qOut == x0In)
  );

  // A forced load is visible on the next cycle when stored data is shown
  assert_force_R9 : assert property (
    @(posedge clk) disable iff (!rstN)
    forceInit |=> (!storeCode || forceBypass[0] || qOut == $past(initVal))
  );

endmodule

// File: tb/evff_stage_tb.sv
module evff_stage_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] modeSel;
  logic       x0In, x1In, forceInit, initVal;
  logic [1:0] forceBypass;
  logic       qOut, qnOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // Bench model state
  logic mq, mprev;

  always #(CLK_PERIOD/2) clk = ~clk;

  evff_stage u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .x0In(x0In), .x1In(x1In),
    .forceInit(forceInit), .initVal(initVal), .forceBypass(forceBypass),
    .qOut(qOut), .qnOut(qnOut)
  );

  function automatic bit isStore(logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd5);
  endfunction

  function automatic logic nextQ();
    logic rise;
    rise = x1In & ~mprev;
    if (forceInit) return initVal;
    case (modeSel)
      3'd1: return x0In ? 1'b0 : (x1In ? 1'b1 : mq);
      3'd2: return (rise && x0In) ? ~mq : mq;
      3'd3, 3'd4: return rise ? x0In : mq;
      3'd5: return x1In ? x0In : mq;
      default: return mq;
    endcase
  endfunction

  function automatic logic expQ();
    if (forceBypass[0] || !isStore(modeSel)) return x0In;
    return mq;
  endfunction

  function automatic logic expQn();
    if (forceBypass[1] || !isStore(modeSel)) return x1In;
    return ~mq;
  endfunction

  function automatic string modeTag(logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b (mode %0d)", tag, act, exp, modeSel);
    end
  endtask

  // Compare outputs, then advance one clock and the model
  task automatic cycle(string tag);
    string qnTag;
    #1;
    qnTag = (isStore(modeSel) && forceBypass == 2'b00) ? "R8" : tag;
    check(tag, qOut, expQ());
    check(qnTag, qnOut, expQn());
    @(posedge clk);
    mq    = nextQ();
    mprev = x1In;
    @(negedge clk);
  endtask

  task automatic jkStep(logic j, logic k);
    logic qNow;
    logic want;
    qNow = qOut;
    want = (j & ~qNow) | (~k & qNow);
    x0In = want;
    x1In = 1'b1;
    cycle("R6");
    x1In = 1'b0;
    cycle("R6");
    #1 check("R6", qOut, want);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0e5f_1a11));
    rstN = 1'b0; modeSel = 3'd3; x0In = 1'b1; x1In = 1'b1;
    forceInit = 1'b0; initVal = 1'b0; forceBypass = 2'b00;
    mq = 1'b0; mprev = 1'b0;
    repeat (3) @(negedge clk);
    // R1: stored bit is zero in reset
    check("R1", qOut, 1'b0);
    check("R1", qnOut, 1'b1);
    rstN = 1'b1;
    // R1: X1 already high counts as a rising edge in the first cycle
    cycle("R1");
    #1 check("R1", qOut, 1'b1);
    x1In = 1'b0; x0In = 1'b0;
    cycle("R5");

    // R3: set, then set and reset together
    modeSel = 3'd1; x0In = 1'b0; x1In = 1'b1;
    cycle("R3");
    #1 check("R3", qOut, 1'b1);
    x0In = 1'b1; x1In = 1'b1;
    cycle("R3");
    #1 check("R3", qOut, 1'b0);
    x0In = 1'b0; x1In = 1'b0;
    cycle("R3");
    #1 check("R3", qOut, 1'b0);

    // R11: long high level on X1 toggles only once
    modeSel = 3'd2; x0In = 1'b1; x1In = 1'b1;
    repeat (5) cycle("R11");
    #1 check("R11", qOut, 1'b1);
    x1In = 1'b0;
    cycle("R4");

    // R6: JK through feedback of qOut
    modeSel = 3'd4; x1In = 1'b0;
    cycle("R6");
    jkStep(1'b1, 1'b1);
    jkStep(1'b1, 1'b1);
    jkStep(1'b1, 1'b0);
    jkStep(1'b0, 1'b0);
    jkStep(1'b0, 1'b1);
    jkStep(1'b0, 1'b0);

    // R9: force collides with an active reset in mode 1
    modeSel = 3'd1; x0In = 1'b1; x1In = 1'b0; forceInit = 1'b1; initVal = 1'b1;
    cycle("R9");
    forceInit = 1'b0;
    #1 check("R9", qOut, 1'b1);
    x0In = 1'b0;
    cycle("R3");

    // R10: bypass bits in latch mode
    modeSel = 3'd5; forceBypass = 2'b01; x0In = 1'b0; x1In = 1'b0;
    #1 check("R10", qOut, 1'b0);
    check("R10", qnOut, ~mq);
    forceBypass = 2'b10; x1In = 1'b1; x0In = 1'b1;
    #1 check("R10", qnOut, 1'b1);
    cycle("R10");
    forceBypass = 2'b00; x1In = 1'b0;
    cycle("R7");

    // Random phase over all codes
    for (int i = 0; i < 2400; i++) begin
      if (i % 40 == 0) modeSel = 3'($urandom % 8);
      x0In        = 1'($urandom);
      x1In        = 1'($urandom);
      forceInit   = ($urandom % 16 == 0);
      initVal     = 1'($urandom);
      forceBypass = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      if (forceBypass != 2'b00)  cycle("R10");
      else if (forceInit)        cycle("R9");
      else                       cycle(modeTag(modeSel));
    end

    done = 1;
    summary();
    $finish;
  end

endmodule